// File: doc/BRIEF.md
# DMA Channel Control Register and Interrupt Unit

This block is the software-visible control side of a simple bus-master DMA channel placed in front of a peripheral such as a disk or network controller. It holds four 32-bit registers reached through a word-only register port: a control/status word, a transfer address, a byte count and a base register for the upper address. It does not move data. It tracks the peripheral's interrupt request and passes it to the processor only when software has enabled it. It also drives a one-cycle reset pulse and a level enable signal toward the peripheral.

A data-path engine sits beside it. After each finished transfer that engine pulses a completion strobe with the byte length, and the address register advances by that length. A parameter selects the network-style variant. In that variant the address register does not advance, and every memory address the engine issues is ORed with the base register. Register reads have no wait states.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset the control/status word reads 0xA0000000, the other three registers read 0, and irq_out, periph_rst and dma_en_out are 0.
- R2: The register is selected by bus_addr[3:2]: 0 control/status, 1 address, 2 count, 3 base. bus_addr[4] is ignored, so offsets 0x10–0x1F alias 0x00–0x0F. Reads return the stored word in the same cycle, and writes to count and base store the word unchanged.
- R3: On a control write, bits 0–2 and 25–31 keep their old values, all other bits take the written value, and bits 31:28 always read 0xA.
- R4: A control write with bit 7 (reset) set makes periph_rst high for exactly the following cycle and stores bit 6 as written. Without bit 7, a set bit 6 (drain) is stored as 0.
- R5: A control write of the all-zero word stores bit 6 as 1.
- R6: dma_en_out rises in the cycle after bit 9 (DMA enable) changes from 0 to 1, and falls in the cycle after it changes from 1 to 0.
- R7: A write to the address register stores the word and sets bit 26 (address loaded) of control/status. Later control writes keep bit 26.
- R8: A rising edge on periph_irq sets bit 0 (interrupt pending), and a falling edge clears it. Each edge takes effect at the first clock that samples it.
- R9: irq_out is high exactly when pending (bit 0) and interrupt enable (bit 4) are both set. It updates one clock after the event: an edge on periph_irq, or a control write that sets or clears bit 4.
- R10: In the default variant (NET_MODE=0), xfer_done adds xfer_len to the address register. A register write to the address in the same cycle takes priority.
- R11: With NET_MODE=1, mem_addr_out equals mem_addr_in ORed with the base register and xfer_done has no effect. With NET_MODE=0, mem_addr_out equals mem_addr_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Byte offset of the word |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, combinational |
| periph_irq | input | 1 | Interrupt level from the peripheral |
| irq_out | output | 1 | Gated interrupt to the processor |
| periph_rst | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en_out | output | 1 | DMA enable level to the peripheral |
| xfer_done | input | 1 | Transfer completion strobe |
| xfer_len | input | 16 | Bytes moved by the finished transfer |
| mem_addr_in | input | 32 | Address requested by the data path |
| mem_addr_out | output | 32 | Address issued to memory |

## Verification
A wrong read-only mask or a missing version OR shows up in the first read of control/status after a control write. A stale pending bit shows up one clock after the next enable write, because irq_out then disagrees with the read-back word. A bad reset pulse or a bad enable edge shows on periph_rst or dma_en_out in the cycle right after the write. A faulty address adder shows up in the next read of the address register.

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs #(
  parameter int NET_MODE = 0,
  parameter int LEN_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [4:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             periph_irq,
  output logic             irq_out,
  output logic             periph_rst,
  output logic             dma_en_out,
  input  logic             xfer_done,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [31:0]      mem_addr_in,
  output logic [31:0]      mem_addr_out
);
  localparam logic [31:0] VERSION = 32'hA000_0000;
  localparam logic [31:0] KEEP    = 32'hFE00_0007;

  logic [31:0] r_csr, r_addr, r_cnt, r_base;
  logic [31:0] wval, csr_next;
  logic        irq_q;

  wire [1:0] idx     = bus_addr[3:2];
  wire       wr      = bus_sel & bus_we;
  wire       wr_csr  = wr && idx == 2'd0;
  wire       wr_addr = wr && idx == 2'd1;
  wire       wr_cnt  = wr && idx == 2'd2;
  wire       wr_base = wr && idx == 2'd3;
  wire       irq_rise = periph_irq & ~irq_q;
  wire       irq_fall = ~periph_irq & irq_q;

  always_comb begin
    wval = bus_wdata;
    if (!bus_wdata[7]) begin
      if (bus_wdata[6]) wval[6] = 1'b0;
      else if (bus_wdata == 32'd0) wval[6] = 1'b1;
    end
  end

  always_comb begin
    csr_next = wr_csr ? ((r_csr & KEEP) | (wval & ~KEEP) | VERSION) : r_csr;
    if (wr_addr) csr_next[26] = 1'b1;
    if (irq_rise) csr_next[0] = 1'b1;
    else if (irq_fall) csr_next[0] = 1'b0;
  end

  always_comb begin
    case (idx)
      2'd0:    bus_rdata = r_csr;
      2'd1:    bus_rdata = r_addr;
      2'd2:    bus_rdata = r_cnt;
      default: bus_rdata = r_base;
    endcase
  end

  generate
    if (NET_MODE != 0) begin : g_net
      assign mem_addr_out = mem_addr_in | r_base;
    end else begin : g_plain
      assign mem_addr_out = mem_addr_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_csr      <= VERSION;
      r_addr     <= '0;
      r_cnt      <= '0;
      r_base     <= '0;
      irq_q      <= 1'b0;
      irq_out    <= 1'b0;
      periph_rst <= 1'b0;
      dma_en_out <= 1'b0;
    end else begin
      irq_q      <= periph_irq;
      r_csr      <= csr_next;
      irq_out    <= csr_next[0] & csr_next[4];
      dma_en_out <= csr_next[9];
      periph_rst <= wr_csr & bus_wdata[7];
      if (wr_addr) r_addr <= bus_wdata;
      else if (xfer_done && NET_MODE == 0)
        r_addr <= r_addr + {{(32-LEN_W){1'b0}}, xfer_len};
      if (wr_cnt)  r_cnt  <= bus_wdata;
      if (wr_base) r_base <= bus_wdata;
    end
  end
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [4:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        irq_out,
  input logic        periph_rst,
  input logic        dma_en_out,
  input logic [31:0] csr
);
  // R1 / R3: version nibble is fixed
  a_r3_version: assert property (@(posedge clk) disable iff (!rst_n)
    csr[31:28] == 4'hA);
  // R9
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (csr[0] & csr[4]));
  // R6
  a_r6_en_level: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en_out == csr[9]);
  // R4
  a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_rst) |-> $past(bus_sel && bus_we && bus_addr[3:2] == 2'd0 && bus_wdata[7]));
  // R7
  a_r7_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[3:2] == 2'd1) |=> csr[26]);
  // R3: read-only upper bits survive a control write
  a_r3_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[3:2] == 2'd0) |=> $stable(csr[27:25]));
endmodule

bind dma_ctl_regs dma_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_out(irq_out),
  .periph_rst(periph_rst), .dma_en_out(dma_en_out), .csr(r_csr)
);

// File: tb/tb_dma_ctl_regs.sv
`timescale 1ns/1ps
module tb_dma_ctl_regs;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic periph_irq = 0, xfer_done = 0;
  logic [15:0] xfer_len = 0;
  logic [31:0] mem_addr_in = 0;
  logic [31:0] rdata, rdata_e, maddr, maddr_e;
  logic irq_out, periph_rst, dma_en_out;
  logic irq_e, prst_e, en_e;

  always #2.5 clk = ~clk;

  dma_ctl_regs #(.NET_MODE(0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .periph_irq(periph_irq), .irq_out(irq_out), .periph_rst(periph_rst),
    .dma_en_out(dma_en_out), .xfer_done(xfer_done), .xfer_len(xfer_len),
    .mem_addr_in(mem_addr_in), .mem_addr_out(maddr));

  dma_ctl_regs #(.NET_MODE(1)) dut_net (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_e),
    .periph_irq(periph_irq), .irq_out(irq_e), .periph_rst(prst_e),
    .dma_en_out(en_e), .xfer_done(xfer_done), .xfer_len(xfer_len),
    .mem_addr_in(mem_addr_in), .mem_addr_out(maddr_e));

  int total = 0, bad = 0;
  int sel_q[$];
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit finished = 0;

  // sel: 0 rdata, 1 irq_out, 2 periph_rst, 3 dma_en_out, 4 mem_addr_out,
  //      5 rdata (net variant), 6 mem_addr_out (net variant)
  function automatic logic [31:0] observe(int s);
    case (s)
      0: return rdata;
      1: return {31'd0, irq_out};
      2: return {31'd0, periph_rst};
      3: return {31'd0, dma_en_out};
      4: return maddr;
      5: return rdata_e;
      default: return maddr_e;
    endcase
  endfunction

  always @(negedge clk) begin
    while (sel_q.size() != 0) begin
      int s;
      logic [31:0] e, a;
      string t;
      s = sel_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = observe(s);
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", t, a, e);
      end
    end
  end

  function automatic void push(int s, logic [31:0] e, string t);
    sel_q.push_back(s);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endfunction

  task automatic settle();
    wait (sel_q.size() == 0);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, bit xf = 0, logic [15:0] len = 0);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    xfer_done = xf; xfer_len = len;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0; xfer_done = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic irq_level(logic v);
    @(negedge clk);
    periph_irq = v;
    @(posedge clk); #1;
  endtask

  task automatic xfer(logic [15:0] len);
    @(negedge clk);
    xfer_done = 1; xfer_len = len;
    @(posedge clk); #1;
    xfer_done = 0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] e, string t, int s = 0);
    bus_addr = a;
    push(s, e, t);
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(5'h00, 32'hA000_0000, "R1 csr reset");
    rd(5'h04, 32'h0, "R1 addr reset");
    rd(5'h0C, 32'h0, "R1 base reset");
    push(1, 0, "R1 irq_out reset"); push(2, 0, "R1 periph_rst reset");
    push(3, 0, "R1 dma_en reset"); settle();

    wr(5'h00, 32'h0000_0210);
    rd(5'h00, 32'hA000_0210, "R3 csr enable write");
    push(3, 1, "R6 dma_en rise"); push(1, 0, "R9 no pending"); settle();

    irq_level(1);
    rd(5'h00, 32'hA000_0211, "R8 pending set");
    push(1, 1, "R9 irq on with enable"); settle();

    wr(5'h00, 32'h0);
    rd(5'h00, 32'hA000_0041, "R5 zero write drain");
    push(1, 0, "R9 irq off by disable"); push(3, 0, "R6 dma_en fall"); settle();

    wr(5'h00, 32'h0000_0010);
    push(1, 1, "R9 irq on by enable write"); settle();

    irq_level(0);
    rd(5'h00, 32'hA000_0010, "R8 pending cleared");
    push(1, 0, "R9 irq off by falling edge"); settle();

    wr(5'h00, 32'h5E00_0057);
    rd(5'h00, 32'hA000_0010, "R3 read-only bits and drain clear R4");

    irq_level(1);
    rd(5'h00, 32'hA000_0011, "R8 pending set again");
    wr(5'h00, 32'h0000_0100);
    rd(5'h00, 32'hA000_0101, "R3 pending preserved");
    push(1, 0, "R9 pending without enable"); settle();
    irq_level(0);

    wr(5'h00, 32'h0000_00C0);
    push(2, 1, "R4 reset pulse high"); settle();
    tick();
    push(2, 0, "R4 reset pulse ends"); settle();
    rd(5'h00, 32'hA000_00C0, "R4 drain kept with reset");

    wr(5'h04, 32'h0000_1000);
    rd(5'h00, 32'hA400_00C0, "R7 loaded bit");
    rd(5'h04, 32'h0000_1000, "R7 address stored");
    wr(5'h00, 32'h0);
    rd(5'h00, 32'hA400_0040, "R7 loaded kept by control write");

    xfer(16'h0020);
    rd(5'h04, 32'h0000_1020, "R10 address advance");
    rd(5'h04, 32'h0000_1000, "R11 net variant no advance", 5);
    rd(5'h14, 32'h0000_1020, "R2 alias read");

    wr(5'h18, 32'hDEAD_BEEF);
    rd(5'h08, 32'hDEAD_BEEF, "R2 count via alias");
    wr(5'h04, 32'h0000_2000, 1, 16'h0008);
    rd(5'h04, 32'h0000_2000, "R10 write beats xfer_done");

    wr(5'h0C, 32'hF000_0000);
    rd(5'h0C, 32'hF000_0000, "R2 base store");
    mem_addr_in = 32'h0012_3456;
    #1;
    push(4, 32'h0012_3456, "R11 plain passthrough");
    push(6, 32'hF012_3456, "R11 net OR base"); settle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule